// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers eight interrupt request lines, picks the most urgent one under a fixed priority order and raises a single interrupt towards the processor. When the processor answers with an acknowledge cycle, the controller puts an 8-bit vector on the data bus. The vector is the winning line's index added to a base that software programs. Software also programs a mask for each line, and it sends an end-of-interrupt command to release a line once its handler is done.

Each line has an in-service bit. It is set when that line is acknowledged, and while it is set it holds off every request of the same or lower priority. Requests of higher priority can still interrupt, so handlers nest. One controller can run as master and others as slaves, which gives more than eight vectors. A master line marked as cascaded hands the vector cycle to the slave whose 3-bit identity matches that line's number. Each slave uses its own vector base, so every controller owns a separate vector range, such as 0x08–0x0F on the master and 0x70–0x77 on a slave.

Register map, written with `wr_en`, `wr_addr` and `wr_data`:
- Address 0: vector base.
- Address 1: line mask.
- Address 2: cascade map, used in master role only.
- Address 3: end-of-interrupt command.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, all eight lines are masked (mask register 0xFF), no line is in service, the cascade map is clear and the base is 0. `irq_out`, `vec_oe` and `cas_en` are low even when every request line is high.
- R2: A write to address 0 stores `wr_data` with bits 2:0 forced to zero. An acknowledged line's vector is that base plus the line index.
- R3: Line 0 has the highest priority and line 7 the lowest. `irq_out` is high in the same cycle in which any eligible request is present, and the acknowledge picks the lowest-numbered eligible line.
- R4: A line whose bit is 1 in the mask register (address 1) never wins arbitration and never raises `irq_out`.
- R5: An acknowledge sets the winner's in-service bit at the closing clock edge. A request on that line or on any higher-numbered line is then ineligible, while a lower-numbered line can still interrupt.
- R6: Writes to address 3 end an interrupt:
  - with `wr_data[7]`=0, the command clears the in-service bit of line `wr_data[2:0]`;
  - with `wr_data[7]`=1, it clears the lowest-numbered set in-service bit.
- R7: An acknowledge with no eligible request drives base+7 and leaves the in-service bits unchanged.
- R8: In master role (`role_master`=1), acknowledging a line whose cascade-map bit (address 2) is 1 does three things: it raises `cas_en`, drives the line index on `cas_sel`, and keeps `vec_oe` low. The master still sets its own in-service bit for that line.
- R9: In slave role, the controller drives a vector and updates in-service state only in an acknowledge cycle in which `cas_en_in`=1 and `cas_in` equals `slave_id`. Otherwise `vec_oe` stays low.
- R10: `vec_oe` and `cas_en` are high only in a cycle with `inta`=1. When `vec_oe` is low, `vec_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| role_master | input | 1 | 1 = master role, 0 = slave role |
| slave_id | input | 3 | Identity this controller answers to in slave role |
| irq_req | input | 8 | Level-sensitive request lines, bit 0 most urgent |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 base, 1 mask, 2 cascade map, 3 end of interrupt) |
| wr_data | input | VEC_W | Register write data |
| inta | input | 1 | Acknowledge cycle from the processor, one cycle per acknowledge |
| cas_en_in | input | 1 | Cascade select valid from the master (slave role) |
| cas_in | input | 3 | Cascade identity from the master (slave role) |
| irq_out | output | 1 | Interrupt request towards the processor or master |
| vec_oe | output | 1 | Vector drive enable |
| vec_out | output | VEC_W | Vector value |
| cas_en | output | 1 | Cascade select valid (master role) |
| cas_sel | output | 3 | Identity of the slave that owns this acknowledge |

## Verification
`irq_out`, `vec_oe`, `vec_out`, `cas_en` and `cas_sel` are combinational from inputs and held state. They are therefore due in the same cycle as the stimulus. Register writes, in-service updates from an acknowledge and end-of-interrupt clears take effect at the edge that closes the cycle, so their effect is due in the next cycle. The bench changes inputs 1 ns after a rising edge. On every falling edge it compares all outputs of a master and a cascaded slave against a behavioural model. The model's state advances on the same rising edge that the design's registers use.

// File: rtl/irq_pkg.sv
// Shared constants and types of the interrupt controller.
// Assumes exactly eight request lines per controller.
package irq_pkg;
    localparam int LINES = 8;
    localparam int IDX_W = $clog2(LINES);

    typedef enum logic [1:0] {
        REG_BASE = 2'd0,
        REG_MASK = 2'd1,
        REG_CASC = 2'd2,
        REG_EOI  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } win_t;
endpackage

// File: rtl/irq_cfg_regs.sv
// Holds the programmable state of one controller: vector base, line mask and
// cascade map. It also decodes end-of-interrupt commands into one-cycle strobes.
// Assumes VEC_W >= LINES, so that a full mask fits in one write.
module irq_cfg_regs
    import irq_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [VEC_W-1:0] wr_data,
    output logic [VEC_W-1:0] base_q,
    output logic [LINES-1:0] mask_q,
    output logic [LINES-1:0] casc_q,
    output logic             eoi_spec,
    output logic             eoi_any,
    output logic [IDX_W-1:0] eoi_idx
);
    logic eoi_hit;

    // Register writes; the base always keeps its low index bits at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '1;
            casc_q <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_BASE: base_q <= {wr_data[VEC_W-1:IDX_W], IDX_W'(0)};
                REG_MASK: mask_q <= wr_data[LINES-1:0];
                REG_CASC: casc_q <= wr_data[LINES-1:0];
                default:  ;
            endcase
        end
    end

    // Decode of the end-of-interrupt command into specific or any-highest form.
    always_comb begin
        eoi_hit  = wr_en && (reg_addr_e'(wr_addr) == REG_EOI);
        eoi_any  = eoi_hit && wr_data[VEC_W-1];
        eoi_spec = eoi_hit && !wr_data[VEC_W-1];
        eoi_idx  = wr_data[IDX_W-1:0];
    end
endmodule

// File: rtl/irq_resolver.sv
// Fixed-priority arbiter. Line 0 is most urgent. A line is eligible when it is
// requested, unmasked and no line of equal or higher priority is in service.
// Purely combinational.
module irq_resolver
    import irq_pkg::*;
(
    input  logic [LINES-1:0] req,
    input  logic [LINES-1:0] mask,
    input  logic [LINES-1:0] isr,
    output win_t             win
);
    logic [LINES-1:0] held;
    logic [LINES-1:0] cand;

    // held[i] is high when any of lines 0..i is in service.
    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_held
            if (g == 0) begin : g_first
                assign held[g] = isr[g];
            end else begin : g_rest
                assign held[g] = held[g-1] | isr[g];
            end
        end
    endgenerate

    assign cand = req & ~mask & ~held;

    // Pick the lowest-numbered candidate.
    always_comb begin
        win = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (cand[i]) begin
                win.valid = 1'b1;
                win.idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_service.sv
// In-service bits. An acknowledge sets the winner's bit. An end-of-interrupt
// clears either the named bit or the most urgent set bit. When both happen in
// one cycle, the set is applied before the clear.
module irq_service
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             eoi_spec,
    input  logic             eoi_any,
    input  logic [IDX_W-1:0] eoi_idx,
    output logic [LINES-1:0] isr_q
);
    logic [LINES-1:0] set_vec;
    logic [LINES-1:0] clr_vec;

    // Build the set and clear masks for this cycle.
    always_comb begin
        set_vec = set_en ? (LINES'(1) << set_idx) : '0;
        if (eoi_spec) begin
            clr_vec = LINES'(1) << eoi_idx;
        end else if (eoi_any) begin
            clr_vec = isr_q & (~isr_q + LINES'(1));
        end else begin
            clr_vec = '0;
        end
    end

    // Update the in-service bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else begin
            isr_q <= (isr_q | set_vec) & ~clr_vec;
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Top of the eight-line priority interrupt controller. It resolves requests,
// raises irq_out, and answers the acknowledge cycle with a vector. In master
// role it can instead hand the acknowledge to a slave on a cascaded line.
// Assumes inta is high for exactly one cycle per acknowledge and that requests
// are level-held until acknowledged.
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             role_master,
    input  logic [2:0]       slave_id,
    input  logic [7:0]       irq_req,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [VEC_W-1:0] wr_data,
    input  logic             inta,
    input  logic             cas_en_in,
    input  logic [2:0]       cas_in,
    output logic             irq_out,
    output logic             vec_oe,
    output logic [VEC_W-1:0] vec_out,
    output logic             cas_en,
    output logic [2:0]       cas_sel
);
    localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(LINES - 1);

    logic [VEC_W-1:0] base_q;
    logic [LINES-1:0] mask_q;
    logic [LINES-1:0] casc_q;
    logic [LINES-1:0] isr_q;
    logic             eoi_spec;
    logic             eoi_any;
    logic [IDX_W-1:0] eoi_idx;
    logic             take;
    win_t             win;

    irq_cfg_regs #(.VEC_W(VEC_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .base_q  (base_q),
        .mask_q  (mask_q),
        .casc_q  (casc_q),
        .eoi_spec(eoi_spec),
        .eoi_any (eoi_any),
        .eoi_idx (eoi_idx)
    );

    irq_resolver u_res (
        .req (irq_req),
        .mask(mask_q),
        .isr (isr_q),
        .win (win)
    );

    irq_service u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (take),
        .set_idx (win.idx),
        .eoi_spec(eoi_spec),
        .eoi_any (eoi_any),
        .eoi_idx (eoi_idx),
        .isr_q   (isr_q)
    );

    assign irq_out = win.valid;

    // Acknowledge handling: drive the vector or hand the cycle to a slave.
    always_comb begin
        take    = 1'b0;
        vec_oe  = 1'b0;
        vec_out = '0;
        cas_en  = 1'b0;
        cas_sel = '0;
        if (inta) begin
            if (role_master) begin
                take = win.valid;
                if (win.valid && casc_q[win.idx]) begin
                    cas_en  = 1'b1;
                    cas_sel = win.idx;
                end else begin
                    vec_oe = 1'b1;
                end
            end else if (cas_en_in && (cas_in == slave_id)) begin
                take   = win.valid;
                vec_oe = 1'b1;
            end
        end
        if (vec_oe) begin
            vec_out = base_q | VEC_W'(win.valid ? win.idx : SPUR_IDX);
        end
    end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
// Property checker for irq_prio_ctrl, attached to every instance by bind.
module irq_prio_ctrl_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             role_master,
    input logic [2:0]       slave_id,
    input logic [7:0]       irq_req,
    input logic [7:0]       mask_q,
    input logic [7:0]       isr_q,
    input logic [VEC_W-1:0] base_q,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             inta,
    input logic             cas_en_in,
    input logic [2:0]       cas_in,
    input logic             irq_out,
    input logic             vec_oe,
    input logic [VEC_W-1:0] vec_out,
    input logic             cas_en
);
    logic eoi_wr;
    assign eoi_wr = wr_en && (wr_addr == 2'd3);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!irq_out && !vec_oe && !cas_en));

    p_vec_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> (vec_out[VEC_W-1:3] == base_q[VEC_W-1:3]));

    p_masked_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((irq_req & ~mask_q) != 8'h00));

    p_isr_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && irq_out && (vec_oe || cas_en) && !eoi_wr)
        |=> ($countones(isr_q) == $countones($past(isr_q)) + 1));

    p_spurious_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !irq_out && !eoi_wr) |=> (isr_q == $past(isr_q)));

    p_cascade_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cas_en |-> (!vec_oe && role_master));

    p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!role_master && !(cas_en_in && (cas_in == slave_id))) |-> !vec_oe);

    p_ack_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe || cas_en) |-> inta);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .role_master(role_master),
    .slave_id   (slave_id),
    .irq_req    (irq_req),
    .mask_q     (mask_q),
    .isr_q      (isr_q),
    .base_q     (base_q),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .inta       (inta),
    .cas_en_in  (cas_en_in),
    .cas_in     (cas_in),
    .irq_out    (irq_out),
    .vec_oe     (vec_oe),
    .vec_out    (vec_out),
    .cas_en     (cas_en)
);

// File: tb/irq_prio_ctrl_bench.sv
// Master plus one slave on master line 2, compared each cycle with a model.
module irq_prio_ctrl_bench;
    localparam int SID = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] m_req, s_req, wr_data;
    logic [1:0] wr_addr;
    logic       m_wr, s_wr, inta;
    logic       m_irq, m_vec_oe, m_cas_en, s_irq, s_vec_oe, s_cas_en;
    logic [7:0] m_vec, s_vec;
    logic [2:0] m_cas_sel, s_cas_sel;
    logic [7:0] m_in;

    int    compared = 0;
    int    mismatched = 0;
    int    cycles = 0;
    bit    done = 0;
    string cur_req = "R1";

    // model state
    logic [7:0] mb = 8'h00, mm = 8'hFF, mc = 8'h00, mi = 8'h00;
    logic [7:0] sb = 8'h00, sm = 8'hFF, si = 8'h00;
    // model outputs
    int         ws, wm;
    logic       e_m_irq, e_m_oe, e_m_cas, e_s_irq, e_s_oe;
    logic [7:0] e_m_vec, e_s_vec;
    logic [2:0] e_m_sel;

    always #2.5ns clk = ~clk;

    assign m_in = {m_req[7:3], s_irq, m_req[1:0]};

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .role_master(1'b1), .slave_id(3'd0),
        .irq_req(m_in), .wr_en(m_wr), .wr_addr(wr_addr), .wr_data(wr_data),
        .inta(inta), .cas_en_in(1'b0), .cas_in(3'd0),
        .irq_out(m_irq), .vec_oe(m_vec_oe), .vec_out(m_vec),
        .cas_en(m_cas_en), .cas_sel(m_cas_sel)
    );

    irq_prio_ctrl u_slave (
        .clk(clk), .rst_n(rst_n), .role_master(1'b0), .slave_id(3'(SID)),
        .irq_req(s_req), .wr_en(s_wr), .wr_addr(wr_addr), .wr_data(wr_data),
        .inta(inta), .cas_en_in(m_cas_en), .cas_in(m_cas_sel),
        .irq_out(s_irq), .vec_oe(s_vec_oe), .vec_out(s_vec),
        .cas_en(s_cas_en), .cas_sel(s_cas_sel)
    );

    function automatic int pick(logic [7:0] req, logic [7:0] msk, logic [7:0] isr);
        for (int i = 0; i < 8; i++) begin
            if (isr[i]) return -1;
            if (req[i] && !msk[i]) return i;
        end
        return -1;
    endfunction

    function automatic logic [7:0] lowest(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return 8'(1) << i;
        return 8'h00;
    endfunction

    task automatic model_eval();
        ws      = pick(s_req, sm, si);
        e_s_irq = (ws >= 0);
        wm      = pick({m_req[7:3], e_s_irq, m_req[1:0]}, mm, mi);
        e_m_irq = (wm >= 0);
        e_m_oe = 0; e_m_cas = 0; e_m_sel = 0; e_m_vec = 0; e_s_oe = 0; e_s_vec = 0;
        if (inta) begin
            if (wm >= 0 && mc[wm]) begin
                e_m_cas = 1; e_m_sel = 3'(wm);
            end else begin
                e_m_oe = 1; e_m_vec = mb + 8'((wm >= 0) ? wm : 7);
            end
            if (e_m_cas && e_m_sel == 3'(SID)) begin
                e_s_oe = 1; e_s_vec = sb + 8'((ws >= 0) ? ws : 7);
            end
        end
    endtask

    // model state update on the same edge as the design
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            mb = 8'h00; mm = 8'hFF; mc = 8'h00; mi = 8'h00;
            sb = 8'h00; sm = 8'hFF; si = 8'h00;
        end else begin
            logic [7:0] mclr, sclr;
            model_eval();
            mclr = 0; sclr = 0;
            if (m_wr && wr_addr == 2'd3) mclr = wr_data[7] ? lowest(mi) : (8'(1) << wr_data[2:0]);
            if (s_wr && wr_addr == 2'd3) sclr = wr_data[7] ? lowest(si) : (8'(1) << wr_data[2:0]);
            if (inta && wm >= 0) mi[wm] = 1'b1;
            if (e_s_oe && ws >= 0) si[ws] = 1'b1;
            mi = mi & ~mclr;
            si = si & ~sclr;
            if (m_wr) case (wr_addr)
                2'd0: mb = wr_data & 8'hF8;
                2'd1: mm = wr_data;
                2'd2: mc = wr_data;
                default: ;
            endcase
            if (s_wr) case (wr_addr)
                2'd0: sb = wr_data & 8'hF8;
                2'd1: sm = wr_data;
                default: ;
            endcase
        end
    end

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (cycles >= 1 && !done) begin
            model_eval();
            chk("m_irq",   8'(m_irq),     8'(e_m_irq));
            chk("m_vecoe", 8'(m_vec_oe),  8'(e_m_oe));
            chk("m_vec",   m_vec,         e_m_vec);
            chk("m_casen", 8'(m_cas_en),  8'(e_m_cas));
            chk("m_cassel",8'(m_cas_sel), 8'(e_m_sel));
            chk("s_irq",   8'(s_irq),     8'(e_s_irq));
            chk("s_vecoe", 8'(s_vec_oe),  8'(e_s_oe));
            chk("s_vec",   s_vec,         e_s_vec);
            chk("s_casen", 8'(s_cas_en),  8'h00);
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1ns;
    endtask

    task automatic wr(bit to_slave, logic [1:0] a, logic [7:0] d);
        m_wr = !to_slave; s_wr = to_slave; wr_addr = a; wr_data = d;
        step(1);
        m_wr = 0; s_wr = 0; wr_addr = 0; wr_data = 0;
    endtask

    task automatic ack();
        inta = 1; step(1); inta = 0;
    endtask

    initial begin
        rst_n = 0; m_req = 8'hFF; s_req = 8'hFF; m_wr = 0; s_wr = 0;
        wr_addr = 0; wr_data = 0; inta = 0;
        step(3);
        rst_n = 1;
        cur_req = "R1"; step(3);
        m_req = 0; s_req = 0; step(1);

        cur_req = "R2";
        wr(0, 2'd0, 8'h0F); wr(0, 2'd1, 8'hDF);
        m_req = 8'h20; step(1); ack(); m_req = 0; wr(0, 2'd3, 8'h05); step(1);

        cur_req = "R3";
        wr(0, 2'd1, 8'h00);
        m_req = 8'b0100_1010; step(1); ack();
        cur_req = "R6";
        wr(0, 2'd3, 8'h80); step(1); ack();
        wr(0, 2'd3, 8'h03); step(1); ack();
        wr(0, 2'd3, 8'h80); m_req = 0; step(1);

        cur_req = "R4";
        wr(0, 2'd1, 8'h02); m_req = 8'h02; step(3);
        m_req = 8'h03; step(1); ack(); wr(0, 2'd3, 8'h80);
        m_req = 0; wr(0, 2'd1, 8'h00);

        cur_req = "R5";
        m_req = 8'h10; step(1); ack();
        m_req = 8'h50; step(2);
        m_req = 8'h51; step(1); ack();
        m_req = 8'h50; step(2);
        wr(0, 2'd3, 8'h80); step(2);
        wr(0, 2'd3, 8'h04); step(1); m_req = 0; step(1);

        cur_req = "R7";
        step(1); ack(); step(2);
        m_req = 8'h80; step(1); ack(); m_req = 0; wr(0, 2'd3, 8'h07); step(1);

        cur_req = "R8";
        wr(0, 2'd2, 8'h04); wr(1, 2'd0, 8'h75); wr(1, 2'd1, 8'h00);
        s_req = 8'h20; step(2); ack();
        cur_req = "R9";
        s_req = 8'h21; step(2);
        wr(0, 2'd3, 8'h02); step(1); ack(); s_req = 0;
        wr(1, 2'd3, 8'h80); wr(1, 2'd3, 8'h80); wr(0, 2'd3, 8'h02); step(1);
        m_req = 8'h01; s_req = 8'h08; step(1); ack();
        m_req = 0; wr(0, 2'd3, 8'h80); step(1); ack();
        s_req = 0; wr(1, 2'd3, 8'h03); wr(0, 2'd3, 8'h02);

        cur_req = "R10";
        m_req = 8'h44; step(3); m_req = 0; step(2);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++; mismatched++;
            $display("FAIL watchdog %s: actual running expected finished", cur_req);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule